// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Presenter

This block sits between the interrupt routing logic and one processor. Each arriving notification carries an 8-bit priority. The block remembers which priority levels have work waiting in an 8-bit pending map, with one bit per level. From that map it derives the most favoured pending level. A lower number is more favoured, and level 0 is the best.

Software programs a current processor priority. When the best pending level is numerically below that threshold, the block raises a level-sensitive interrupt line and an exception-outstanding flag. Both are dropped again as soon as the condition stops holding. The condition is evaluated on the state that a cycle produces, so a notify and a threshold write in the same cycle are both taken into account.

Software takes an interrupt with an acknowledge strobe. The strobe returns the presented level, retires that level's pending bit and raises the threshold to the acknowledged level.

Top module: `prio_presenter`

## Requirements
- R1: A notify with priority p in 0..7 sets pending bit (7 - p), so priority 0 sets bit 7. A priority from 8 to 254 sets no bit and changes nothing.
- R2: A notify with priority 0xFF is masked and leaves all state unchanged.
- R3: `pend_prio` equals the number of leading zeros of `pend_buf`, counted from bit 7. It reads 0xFF when `pend_buf` is zero.
- R4: A lower numeric priority is more favoured. The interrupt condition is `pend_prio < cur_prio`, with strict inequality.
- R5: `irq_out` is a level. One cycle after any change of the pending map or the threshold, it equals the condition. It falls when the condition stops holding.
- R6: `exc_flag` equals the condition in every cycle, except the cycle right after an acknowledge.
- R7: A threshold write with a value of 0..7 stores that value. A value above 7 stores 0xFF, which masks everything.
- R8: While `ack` is high, `ack_data` shows `pend_prio`. On the clock edge, that level's pending bit clears and `cur_prio` loads the acknowledged value, which is 0xFF if nothing was pending. An acknowledge overrides a threshold write in the same cycle.
- R9: In the cycle after an acknowledge, `exc_flag` is low.
- R10: When several events share a cycle, they are all applied before the comparison. A notify and a threshold write are both applied. When a notify and an acknowledge share a cycle, the acknowledged bit is cleared first and the notify's bit is set afterwards.
- R11: After reset, `pend_buf` is 0, `pend_prio` is 0xFF, `cur_prio` is 0, and `exc_flag`, `irq_out` and `ack_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 8 | Notification priority |
| cur_wr | input | 1 | Threshold write strobe |
| cur_wdata | input | 8 | Threshold write value |
| ack | input | 1 | Acknowledge strobe |
| ack_data | output | 8 | Acknowledged priority (0 when ack is low) |
| pend_buf | output | 8 | Pending map, bit 7 = priority 0 |
| pend_prio | output | 8 | Most favoured pending priority |
| cur_prio | output | 8 | Current processor priority |
| exc_flag | output | 1 | Exception outstanding |
| irq_out | output | 1 | Level interrupt to the processor |

## Verification
Random notifies cover the legal levels, the out-of-range band and the masked code 0xFF. They are mixed with threshold writes on both sides of 7 and with occasional acknowledges. This separates correct bit placement and leading-zero encoding from off-by-one or mirrored mappings. Directed sequences place the pending level equal to, just below and just above the threshold, which distinguishes a strict compare from a non-strict one. Further directed cycles pair notify with write and notify with acknowledge, and issue an acknowledge on an empty map, to expose wrong ordering within a cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int PP_LVLS = 8;
  localparam int PP_PW   = 8;
  localparam int PP_PMAX = PP_LVLS - 1;

  // leading-zero count of the pending map, all-ones when empty
  function automatic logic [PP_PW-1:0] buf_to_prio(input logic [PP_LVLS-1:0] b);
    logic [PP_PW-1:0] r;
    r = '1;
    for (int i = 0; i < PP_LVLS; i++)
      if (b[i]) r = PP_PW'(PP_LVLS - 1 - i);
    return r;
  endfunction

  // out-of-range threshold values become fully masked
  function automatic logic [PP_PW-1:0] clamp_prio(input logic [PP_PW-1:0] v);
    return (v > PP_PW'(PP_PMAX)) ? '1 : v;
  endfunction
endpackage

// File: rtl/pp_pend_buf.sv
module pp_pend_buf
  import pp_pkg::*;
#(
  parameter int LVLS = PP_LVLS,
  parameter int PW   = PP_PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ntf_valid,
  input  logic [PW-1:0]   ntf_prio,
  input  logic            clr_en,
  input  logic [PW-1:0]   clr_prio,
  output logic [LVLS-1:0] pend_q,
  output logic [LVLS-1:0] pend_nx,
  output logic [PW-1:0]   pend_prio
);
  logic [LVLS-1:0] set_vec;
  logic [LVLS-1:0] clr_vec;

  for (genvar i = 0; i < LVLS; i++) begin : g_lvl
    localparam logic [PW-1:0] LVL = PW'(LVLS - 1 - i);
    assign set_vec[i] = ntf_valid && (ntf_prio == LVL);
    assign clr_vec[i] = clr_en && (clr_prio == LVL);
  end

  // clear of the acknowledged level first, then the new notify
  assign pend_nx   = (pend_q & ~clr_vec) | set_vec;
  assign pend_prio = buf_to_prio(pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nx;
  end
endmodule

// File: rtl/pp_cur_reg.sv
module pp_cur_reg
  import pp_pkg::*;
#(
  parameter int PW = PP_PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_wr,
  input  logic [PW-1:0] cur_wdata,
  input  logic          ack,
  input  logic [PW-1:0] ack_val,
  output logic [PW-1:0] cur_q,
  output logic [PW-1:0] cur_nx
);
  always_comb begin
    cur_nx = cur_q;
    if (ack)         cur_nx = ack_val;
    else if (cur_wr) cur_nx = clamp_prio(cur_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_nx;
  end
endmodule

// File: rtl/pp_present.sv
module pp_present
  import pp_pkg::*;
#(
  parameter int LVLS = PP_LVLS,
  parameter int PW   = PP_PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLS-1:0] pend_nx,
  input  logic [PW-1:0]   cur_nx,
  input  logic            ack,
  output logic            eo_q,
  output logic            irq_q
);
  logic [PW-1:0] best_nx;
  logic          cond_nx;

  assign best_nx = buf_to_prio(pend_nx);
  assign cond_nx = best_nx < cur_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eo_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= cond_nx;
      eo_q  <= cond_nx && !ack;
    end
  end
endmodule

// File: rtl/prio_presenter.sv
module prio_presenter
  import pp_pkg::*;
#(
  parameter int LVLS = PP_LVLS,
  parameter int PW   = PP_PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ntf_valid,
  input  logic [PW-1:0]   ntf_prio,
  input  logic            cur_wr,
  input  logic [PW-1:0]   cur_wdata,
  input  logic            ack,
  output logic [PW-1:0]   ack_data,
  output logic [LVLS-1:0] pend_buf,
  output logic [PW-1:0]   pend_prio,
  output logic [PW-1:0]   cur_prio,
  output logic            exc_flag,
  output logic            irq_out
);
  logic [LVLS-1:0] pend_nx;
  logic [PW-1:0]   cur_nx;

  pp_pend_buf #(.LVLS(LVLS), .PW(PW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
    .clr_en(ack), .clr_prio(pend_prio),
    .pend_q(pend_buf), .pend_nx(pend_nx), .pend_prio(pend_prio)
  );

  pp_cur_reg #(.PW(PW)) u_cur (
    .clk(clk), .rst_n(rst_n),
    .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .ack(ack), .ack_val(pend_prio),
    .cur_q(cur_prio), .cur_nx(cur_nx)
  );

  pp_present #(.LVLS(LVLS), .PW(PW)) u_pres (
    .clk(clk), .rst_n(rst_n),
    .pend_nx(pend_nx), .cur_nx(cur_nx), .ack(ack),
    .eo_q(exc_flag), .irq_q(irq_out)
  );

  assign ack_data = ack ? pend_prio : '0;
endmodule

// File: rtl/pp_chk.sv
module pp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ntf_valid,
  input logic [7:0] ntf_prio,
  input logic       cur_wr,
  input logic [7:0] cur_wdata,
  input logic       ack,
  input logic [7:0] pend_buf,
  input logic [7:0] pend_prio,
  input logic [7:0] cur_prio,
  input logic       exc_flag,
  input logic       irq_out
);
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_buf == 8'h00) == (pend_prio == 8'hFF)); // R3
  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && ntf_prio == 8'hFF && !ack) |=> $stable(pend_buf)); // R2
  AST_THRESH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !ack && cur_wdata > 8'd7) |=> cur_prio == 8'hFF); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend_prio < cur_prio)); // R5
  AST_ACK_EO: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !exc_flag); // R9
  AST_ACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_prio == $past(pend_prio)); // R8
  AST_EO_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flag |-> irq_out); // R6
endmodule

bind prio_presenter pp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
  .cur_wr(cur_wr), .cur_wdata(cur_wdata), .ack(ack), .pend_buf(pend_buf),
  .pend_prio(pend_prio), .cur_prio(cur_prio), .exc_flag(exc_flag),
  .irq_out(irq_out)
);

// File: tb/prio_presenter_test.sv
module prio_presenter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ntf_valid = 1'b0, cur_wr = 1'b0, ack = 1'b0;
  logic [7:0] ntf_prio = '0, cur_wdata = '0;
  logic [7:0] ack_data, pend_buf, pend_prio, cur_prio;
  logic exc_flag, irq_out;
  int checks = 0, errors = 0;
  logic [7:0] m_pend = '0, m_cur = '0;
  logic m_eo = 1'b0, m_irq = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_presenter uut (.*);

  // scan priorities from best to worst, return the first one present
  function automatic logic [7:0] best_of(input logic [7:0] b);
    for (int p = 0; p < 8; p++) if (b[7 - p]) return 8'(p);
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] p, input logic w,
                      input logic [7:0] wd, input logic a, input string tag);
    logic [7:0] ap, np, nc;
    ntf_valid = v; ntf_prio = p; cur_wr = w; cur_wdata = wd; ack = a;
    #1;
    ap = best_of(m_pend);
    if (a) chk({tag, "/R8 ack_data"}, ack_data, ap);
    np = m_pend;
    if (a && ap != 8'hFF) np[7 - ap[2:0]] = 1'b0;
    if (v && p <= 8'd7) np[7 - p[2:0]] = 1'b1;
    nc = a ? ap : (w ? ((wd > 8'd7) ? 8'hFF : wd) : m_cur);
    m_pend = np; m_cur = nc;
    m_irq = best_of(np) < nc;
    m_eo = m_irq && !a;
    @(posedge clk); @(negedge clk);
    ntf_valid = 0; cur_wr = 0; ack = 0;
    chk({tag, "/R1 pend_buf"}, pend_buf, m_pend);
    chk({tag, "/R3 pend_prio"}, pend_prio, best_of(m_pend));
    chk({tag, "/R7 cur_prio"}, cur_prio, m_cur);
    chk({tag, "/R5 irq_out"}, {7'd0, irq_out}, {7'd0, m_irq});
    chk({tag, "/R6 exc_flag"}, {7'd0, exc_flag}, {7'd0, m_eo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1D0C);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 pend_buf", pend_buf, 8'h00);
    chk("R11 pend_prio", pend_prio, 8'hFF);
    chk("R11 cur_prio", cur_prio, 8'h00);
    chk("R11 irq", {7'd0, irq_out}, 8'h00);
    chk("R11 eo", {7'd0, exc_flag}, 8'h00);
    chk("R11 ack_data", ack_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: priority 3 with threshold 0: pending, no interrupt
    step(1, 8'd3, 0, 0, 0, "R1 p3");
    chk("R1 bit4", {7'd0, pend_buf[4]}, 8'd1);
    // R4: threshold equal to pending: no interrupt (strict)
    step(0, 0, 1, 8'd3, 0, "R4 equal");
    chk("R4 equal no irq", {7'd0, irq_out}, 8'd0);
    // R4: threshold one above: interrupt
    step(0, 0, 1, 8'd4, 0, "R4 above");
    chk("R4 above irq", {7'd0, irq_out}, 8'd1);
    // R2: masked notify changes nothing
    step(1, 8'hFF, 0, 0, 0, "R2 masked");
    chk("R2 pend kept", pend_buf, 8'h10);
    // R1: out-of-range notify sets nothing
    step(1, 8'd9, 0, 0, 0, "R1 range");
    // R7: clamp writes above 7
    step(0, 0, 1, 8'd9, 0, "R7 clamp");
    chk("R7 clamp FF", cur_prio, 8'hFF);
    // R10: notify and write together
    step(1, 8'd0, 1, 8'd1, 0, "R10 nw");
    chk("R10 irq", {7'd0, irq_out}, 8'd1);
    // R8 R9: acknowledge best level, loads threshold
    step(0, 0, 0, 0, 1, "R9 ack");
    chk("R9 eo low", {7'd0, exc_flag}, 8'd0);
    chk("R8 cur loaded", cur_prio, 8'd0);
    // R10: acknowledge with a concurrent better notify
    step(0, 0, 1, 8'd7, 0, "R10 prep");
    step(1, 8'd1, 0, 0, 1, "R10 ackntf");
    // R8: drain then acknowledge empty map
    step(0, 0, 0, 0, 1, "R8 drain");
    step(0, 0, 0, 0, 1, "R8 drain2");
    step(0, 0, 0, 0, 1, "R8 empty");
    chk("R8 empty cur", cur_prio, 8'hFF);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] p, wd;
      int sel;
      sel = $urandom_range(0, 9);
      p = (sel < 7) ? 8'($urandom_range(0, 7)) : (sel < 9 ? 8'($urandom_range(8, 254)) : 8'hFF);
      wd = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(8, 255)) : 8'($urandom_range(0, 7));
      step($urandom_range(0, 2) != 0, p, $urandom_range(0, 5) == 0, wd,
           $urandom_range(0, 7) == 0, "RND");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule